// File: doc/BRIEF.md
# Nested Trap State Stack

This block holds a small stack of saved processor-state register sets. Interrupt handlers can therefore nest without saving that state in software. When a trap is accepted, the block pushes the interrupted PC, the next-PC and the current mode bits onto the stack. It then raises the trap level, steers general-register accesses to the single alternate bank, and enters kernel, 64-bit, interrupts-off mode. It also computes the handler address. That address comes from a software-supplied table base, and it depends on whether the stack already held entries and on the trap source.

A return pops the top set. The saved PC and next-PC appear on the restore outputs, and the saved mode bits become current again. The alternate bank stays selected until the last level is popped. An entry that arrives while every set is in use is refused and raises an overflow request, so that a spill mechanism outside the block can act. A return with nothing stacked raises an underflow error. Only the bank select and the overflow request leave the block as control signals; the register file and any spill memory are outside it.

Top module: `trap_state_stack`

## Requirements
- R1: After reset the trap level is 0, and the alternate bank is deselected. The mode bits are kernel=0, wide=0, interrupt-enable=1. The handler address, source id, restore outputs and error pulses are all 0.
- R2: A trap request accepted while the level is below DEPTH (default 4) stores an entry and raises the trap level by one. The trap level is visible on the clock edge after the request.
- R3: After every accepted entry, kernelMode=1, wideMode=1, intEnable=0 and altBankSel=1.
- R4: On an accepted entry the handler address becomes vecBase + 512 x (level before entry != 0) + 32 x source, where source is the effective source.
- R5: When perSourceVec=0 the effective source is forced to zero in the handler address. In both modes srcId captures the raw trap source.
- R6: A return with level > 0 lowers the level by one and pulses restoreValid for one cycle. restorePc and restoreNpc then show the values pushed by the matching entry, and the mode bits saved at that entry become current again.
- R7: altBankSel stays 1 after a return that leaves the level above zero. It drops to 0 only when the level returns to zero.
- R8: A trap request at level DEPTH stores nothing, leaves level and mode bits unchanged, and pulses overflowReq for exactly one cycle. The stacked contents stay intact.
- R9: A return at level 0 pulses underflowErr for one cycle and changes no other state.
- R10: When a trap request and a return arrive in the same cycle, the trap takes priority and the return is ignored. This holds even when the trap is refused as an overflow.
- R11: Entries are popped in last-in, first-out order across the full depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Trap entry request |
| trapSrc | input | SRC_W | Trap source number |
| perSourceVec | input | 1 | 1: one vector per source; 0: single shared vector |
| retReq | input | 1 | Return-from-trap request |
| curPc | input | PC_W | PC of the interrupted instruction |
| curNpc | input | PC_W | Next PC of the interrupted flow |
| vecBase | input | PC_W | Software-defined vector table base |
| trapLevel | output | LVL_W | Number of valid stacked entries |
| altBankSel | output | 1 | Alternate general-register bank selected |
| kernelMode | output | 1 | Kernel mode bit |
| wideMode | output | 1 | 64-bit mode bit |
| intEnable | output | 1 | Interrupt enable bit |
| handlerPc | output | PC_W | Handler address of the latest entry |
| srcId | output | SRC_W | Source of the latest accepted entry |
| restorePc | output | PC_W | PC restored by the latest return |
| restoreNpc | output | PC_W | Next PC restored by the latest return |
| restoreValid | output | 1 | One-cycle pulse on a return |
| overflowReq | output | 1 | One-cycle pulse on a refused entry |
| underflowErr | output | 1 | One-cycle pulse on a return at level 0 |

## Verification
The hardest cases to reach are at full depth: a refused entry must leave all four stored sets untouched, and a return that collides with that refused entry must be ignored. The stimulus fills the stack with distinct PCs, fires an overflowing trap alone, and then fires one together with a return. It then drains the stack, so any corrupted slot or wrongly accepted pop shows up in the restored sequence. A sweep over every source number in both vector modes covers the empty and non-empty address groups with a changing table base.

// File: rtl/tss_pkg.sv
package tss_pkg;

  // Mode bits saved with every stacked entry
  typedef struct packed {
    logic kernel;
    logic wide;
    logic intEn;
  } modes_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic nonEmpty;
  } strobe_t;

  localparam modes_t RESET_MODES = '{kernel: 1'b0, wide: 1'b0, intEn: 1'b1};
  localparam modes_t TRAP_MODES  = '{kernel: 1'b1, wide: 1'b1, intEn: 1'b0};

endpackage

// File: rtl/tss_ctrl.sv
module tss_ctrl
  import tss_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trapReq,
  input  logic             retReq,
  input  modes_t           topModes,
  output strobe_t          strb,
  output logic [LVL_W-1:0] trapLevel,
  output modes_t           modes,
  output logic             altBankSel,
  output logic             overflowReq,
  output logic             underflowErr
);

  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] ONE  = LVL_W'(1);

  logic isFull, isEmpty, ovfHit, unfHit;

  always_comb begin
    isFull        = (trapLevel == FULL);
    isEmpty       = (trapLevel == '0);
    strb.push     = trapReq && !isFull;
    strb.pop      = !trapReq && retReq && !isEmpty;
    strb.nonEmpty = !isEmpty;
    ovfHit        = trapReq && isFull;
    unfHit        = !trapReq && retReq && isEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapLevel    <= '0;
      modes        <= RESET_MODES;
      altBankSel   <= 1'b0;
      overflowReq  <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      overflowReq  <= ovfHit;
      underflowErr <= unfHit;
      if (strb.push) begin
        trapLevel  <= trapLevel + ONE;
        modes      <= TRAP_MODES;
        altBankSel <= 1'b1;
      end else if (strb.pop) begin
        trapLevel <= trapLevel - ONE;
        modes     <= topModes;
        if (trapLevel == ONE) altBankSel <= 1'b0;
      end
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    trapLevel <= FULL);  // R2
  AST_ENTRY_MODES: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> kernelMode_w && modes.wide && !modes.intEn && altBankSel);  // R3
  AST_BANK_TRACKS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    altBankSel == (trapLevel != '0));  // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && isFull) |=> (trapLevel == FULL) && overflowReq && $stable(modes));  // R8
  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !trapReq && isEmpty) |=> (trapLevel == '0) && underflowErr);  // R9
  AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && retReq && !isFull) |=> trapLevel == LVL_W'($past(trapLevel) + ONE));  // R10

  logic kernelMode_w;
  assign kernelMode_w = modes.kernel;

endmodule

// File: rtl/tss_datapath.sv
module tss_datapath
  import tss_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PC_W  = 32,
  parameter int SRC_W = 4,
  parameter int SLOT_SHIFT = 5,
  parameter int GROUP_OFFSET = 512,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [LVL_W-1:0] trapLevel,
  input  modes_t           curModes,
  input  logic [SRC_W-1:0] trapSrc,
  input  logic             perSourceVec,
  input  logic [PC_W-1:0]  curPc,
  input  logic [PC_W-1:0]  curNpc,
  input  logic [PC_W-1:0]  vecBase,
  output modes_t           topModes,
  output logic [PC_W-1:0]  handlerPc,
  output logic [SRC_W-1:0] srcId,
  output logic [PC_W-1:0]  restorePc,
  output logic [PC_W-1:0]  restoreNpc,
  output logic             restoreValid
);

  logic [PC_W-1:0] stPc  [DEPTH];
  logic [PC_W-1:0] stNpc [DEPTH];
  modes_t          stMode[DEPTH];

  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [SRC_W-1:0] srcEff;
  logic [PC_W-1:0]  groupOff, slotOff, vecNext;

  always_comb begin
    wrIdx    = IDX_W'(trapLevel);
    rdIdx    = IDX_W'(trapLevel - LVL_W'(1));
    srcEff   = perSourceVec ? trapSrc : '0;
    groupOff = strb.nonEmpty ? PC_W'(GROUP_OFFSET) : '0;
    slotOff  = PC_W'(srcEff) << SLOT_SHIFT;
    vecNext  = vecBase + groupOff + slotOff;
    topModes = stMode[rdIdx];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stPc[g]   <= '0;
        stNpc[g]  <= '0;
        stMode[g] <= RESET_MODES;
      end else if (strb.push && wrIdx == IDX_W'(g)) begin
        stPc[g]   <= curPc;
        stNpc[g]  <= curNpc;
        stMode[g] <= curModes;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      handlerPc    <= '0;
      srcId        <= '0;
      restorePc    <= '0;
      restoreNpc   <= '0;
      restoreValid <= 1'b0;
    end else begin
      restoreValid <= strb.pop;
      if (strb.push) begin
        handlerPc <= vecNext;
        srcId     <= trapSrc;
      end
      if (strb.pop) begin
        restorePc  <= stPc[rdIdx];
        restoreNpc <= stNpc[rdIdx];
      end
    end
  end

  AST_VECTOR_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> handlerPc[SLOT_SHIFT-1:0] == $past(vecBase[SLOT_SHIFT-1:0]));  // R4
  AST_SRC_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> srcId == $past(trapSrc));  // R5
  AST_RESTORE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    restoreValid |=> !restoreValid || $past(strb.pop));  // R6

endmodule

// File: rtl/trap_state_stack.sv
module trap_state_stack
  import tss_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PC_W  = 32,
  parameter int SRC_W = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trapReq,
  input  logic [SRC_W-1:0] trapSrc,
  input  logic             perSourceVec,
  input  logic             retReq,
  input  logic [PC_W-1:0]  curPc,
  input  logic [PC_W-1:0]  curNpc,
  input  logic [PC_W-1:0]  vecBase,
  output logic [LVL_W-1:0] trapLevel,
  output logic             altBankSel,
  output logic             kernelMode,
  output logic             wideMode,
  output logic             intEnable,
  output logic [PC_W-1:0]  handlerPc,
  output logic [SRC_W-1:0] srcId,
  output logic [PC_W-1:0]  restorePc,
  output logic [PC_W-1:0]  restoreNpc,
  output logic             restoreValid,
  output logic             overflowReq,
  output logic             underflowErr
);

  strobe_t strb;
  modes_t  modes, topModes;

  tss_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .trapReq     (trapReq),
    .retReq      (retReq),
    .topModes    (topModes),
    .strb        (strb),
    .trapLevel   (trapLevel),
    .modes       (modes),
    .altBankSel  (altBankSel),
    .overflowReq (overflowReq),
    .underflowErr(underflowErr)
  );

  tss_datapath #(.DEPTH(DEPTH), .PC_W(PC_W), .SRC_W(SRC_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .trapLevel   (trapLevel),
    .curModes    (modes),
    .trapSrc     (trapSrc),
    .perSourceVec(perSourceVec),
    .curPc       (curPc),
    .curNpc      (curNpc),
    .vecBase     (vecBase),
    .topModes    (topModes),
    .handlerPc   (handlerPc),
    .srcId       (srcId),
    .restorePc   (restorePc),
    .restoreNpc  (restoreNpc),
    .restoreValid(restoreValid)
  );

  assign kernelMode = modes.kernel;
  assign wideMode   = modes.wide;
  assign intEnable  = modes.intEn;

endmodule

// File: tb/tb_trap_state_stack.sv
module tb_trap_state_stack;

  localparam int DEPTH = 4;
  localparam int PC_W  = 32;
  localparam int SRC_W = 4;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trapReq = 1'b0, perSourceVec = 1'b1, retReq = 1'b0;
  logic [SRC_W-1:0] trapSrc = '0;
  logic [PC_W-1:0] curPc = '0, curNpc = '0, vecBase = '0;
  logic [LVL_W-1:0] trapLevel;
  logic altBankSel, kernelMode, wideMode, intEnable;
  logic [PC_W-1:0] handlerPc, restorePc, restoreNpc;
  logic [SRC_W-1:0] srcId;
  logic restoreValid, overflowReq, underflowErr;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // Model of the stack
  int mLevel = 0;
  logic [PC_W-1:0] mPc[DEPTH], mNpc[DEPTH];
  logic [2:0] mMode[DEPTH];
  logic [2:0] mCur = 3'b001;  // {kernel, wide, intEn}

  always #5 clk = ~clk;

  trap_state_stack #(.DEPTH(DEPTH), .PC_W(PC_W), .SRC_W(SRC_W)) dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkModes(input string req);
    check(req, {kernelMode, wideMode, intEnable}, mCur);
    check(req, altBankSel, mLevel != 0);
    check(req, trapLevel, mLevel);
  endtask

  // Accepted entry: R2 R3 R4 R5
  task automatic doTrap(input logic [SRC_W-1:0] src, input logic [PC_W-1:0] pc,
                        input logic [PC_W-1:0] npc, input logic psv, input logic [PC_W-1:0] base);
    logic [PC_W-1:0] expH;
    expH = base + ((mLevel != 0) ? 512 : 0) + (psv ? PC_W'(src) * 32 : 0);
    trapReq = 1; trapSrc = src; curPc = pc; curNpc = npc; perSourceVec = psv; vecBase = base;
    @(negedge clk);
    trapReq = 0;
    mPc[mLevel] = pc; mNpc[mLevel] = npc; mMode[mLevel] = mCur;
    mLevel++; mCur = 3'b110;
    checkModes("R2/R3");
    check("R4", handlerPc, expH);
    check("R5", srcId, src);
  endtask

  // Accepted return: R6 R7 R11
  task automatic doRet();
    retReq = 1;
    @(negedge clk);
    retReq = 0;
    mLevel--; mCur = mMode[mLevel];
    checkModes("R6/R7");
    check("R11", restorePc, mPc[mLevel]);
    check("R6", restoreNpc, mNpc[mLevel]);
    check("R6", restoreValid, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    checkModes("R1");
    check("R1", {handlerPc, srcId, restoreValid, overflowReq, underflowErr}, 0);
    check("R1", {restorePc, restoreNpc}, 0);

    // Sweep: every source, both vector modes, empty and nested groups
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 16; s++) begin
        logic [PC_W-1:0] base;
        base = 32'h1000_0000 + PC_W'((m * 16 + s) * 32'h400);
        doTrap(SRC_W'(s), 32'h100 + PC_W'(s), 32'h104 + PC_W'(s), m[0], base);
        doTrap(SRC_W'(15 - s), 32'h200 + PC_W'(s), 32'h204 + PC_W'(s), m[0], base);
        doRet();  // R7: level 1 keeps bank
        check("R7", altBankSel, 1);
        doRet();
        check("R7", altBankSel, 0);
        @(negedge clk);
        check("R6", restoreValid, 0);
      end
    end

    // Fill, overflow, then drain in LIFO order
    for (int i = 0; i < DEPTH; i++)
      doTrap(SRC_W'(i), 32'hA000 + PC_W'(i * 8), 32'hB000 + PC_W'(i * 8), 1, 32'h4000);
    trapReq = 1; trapSrc = 4'h9; curPc = 32'hDEAD; curNpc = 32'hBEEF;
    @(negedge clk);
    trapReq = 0;
    check("R8", overflowReq, 1);
    checkModes("R8");
    check("R8", srcId, DEPTH - 1);
    @(negedge clk);
    check("R8", overflowReq, 0);
    // R10: collision with refused entry, return ignored
    trapReq = 1; retReq = 1;
    @(negedge clk);
    trapReq = 0; retReq = 0;
    check("R10", overflowReq, 1);
    check("R10", restoreValid, 0);
    checkModes("R10");
    for (int i = 0; i < DEPTH; i++) doRet();  // R11 / R8 contents intact

    // R9 underflow at empty
    @(negedge clk);
    retReq = 1;
    @(negedge clk);
    retReq = 0;
    check("R9", underflowErr, 1);
    check("R9", restoreValid, 0);
    checkModes("R9");
    @(negedge clk);
    check("R9", underflowErr, 0);

    // R10: simultaneous trap and return at level 1
    doTrap(4'h3, 32'hC000, 32'hC004, 1, 32'h8000);
    trapReq = 1; retReq = 1; trapSrc = 4'h5; curPc = 32'hC100; curNpc = 32'hC104;
    @(negedge clk);
    trapReq = 0; retReq = 0;
    mPc[1] = 32'hC100; mNpc[1] = 32'hC104; mMode[1] = mCur; mLevel = 2;
    checkModes("R10");
    check("R10", restoreValid, 0);
    check("R10", handlerPc, 32'h8000 + 512 + 5 * 32);
    doRet();
    doRet();

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule